// File: doc/BRIEF.md
# Keyed System Enable Register

This block is a single 16-bit control register on a simple synchronous register bus. It owns two system-wide enables: one that switches the on-chip program memory on or off, and one that switches the external bus on or off. Software can only change the register by writing a full 16-bit word whose upper byte carries the unlock code 8'h5A. Any other word, a partial-byte write, or a write to another address leaves the register untouched.

The memory enable comes out of reset set. A valid write can clear it, but no write can set it again, so once software drops the on-chip memory it stays dropped until the next reset. The external-bus enable can be written either way. A change to it is never applied while an external bus cycle is running. The new value is held as pending and takes effect on the first clock edge at which the bus is idle. A done flag tells software when it is safe to issue the next access.

Reads are registered. The read data shows only the two enable bits. The key byte and the reserved bits always read as zero.

Top module: `keyed_sysctl_reg`

## Requirements
- R1: After synchronous reset, `mem_enable` is 1, `ext_bus_enable` is 0, `change_done` is 1 and `bus_rdata` is 16'h0000.
- R2: A write takes effect when all of these hold in the same cycle: `bus_wr` is high, `bus_addr` equals `REG_ADDR`, `bus_be` is 2'b11, and `bus_wdata[15:8]` equals 8'h5A. The new values appear on the outputs after that clock edge.
- R3: A write whose `bus_wdata[15:8]` is not 8'h5A changes neither enable output.
- R4: Read data bits 15:8 (the key) and bits 7:2 (reserved) are always 0. Bit 1 is the external-bus enable and bit 0 is the memory enable. Values written to bits 7:2 have no effect.
- R5: A valid write with `bus_wdata[0]`=0 clears `mem_enable`. While `mem_enable` is 0, no write can set it. Only reset restores it to 1.
- R6: A valid write sets `ext_bus_enable` to `bus_wdata[1]`, either 0 or 1.
- R7: While `ext_cycle_active` is high, `ext_bus_enable` does not change. A requested change is held pending with `change_done` low, and is applied at the first clock edge where `ext_cycle_active` is low. At that edge `change_done` returns high.
- R8: Writes to any address other than `REG_ADDR` have no effect. Reads of another address return 16'h0000.
- R9: A write with `bus_be` other than 2'b11 is ignored, even if it carries the correct key.
- R10: A read with `bus_rd` high at `REG_ADDR` returns the register value on `bus_rdata` after that clock edge. The value includes any write completed in an earlier cycle. When no read is issued, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 2 | Byte enables (bit 1 = upper byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ext_cycle_active | input | 1 | An external bus cycle is in progress |
| mem_enable | output | 1 | On-chip program memory enable |
| ext_bus_enable | output | 1 | External bus enable |
| change_done | output | 1 | High when no external-bus enable change is pending |

## Verification
The assertions assume the bus inputs are known and stable around each clock edge. They also assume `ext_cycle_active` reflects the real bus state in every cycle. The bench drives every input on the falling edge and samples every output on the next falling edge, so each check sees exactly one rising edge of effect. Bench writes issue `bus_wr` and `bus_rd` as one-cycle pulses. They never issue both strobes at once. They raise `ext_cycle_active` only for the deferral scenario, and hold it across several edges to show the pending state persists.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W = 16;
    localparam int KEY_W  = 8;
    localparam int BE_W   = DATA_W / 8;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'h5A;
    localparam int MEM_BIT = 0;
    localparam int EXT_BIT = 1;

    typedef struct packed {
        logic ext_bus_en;
        logic mem_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{ext_bus_en: 1'b0, mem_en: 1'b1};

    typedef struct packed {
        logic hit;
        logic ext_val;
        logic mem_clr;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] pack_view(ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[EXT_BIT] = c.ext_bus_en;
        v[MEM_BIT] = c.mem_en;
        return v;
    endfunction

endpackage

// File: rtl/sysctl_wr_qualify.sv
module sysctl_wr_qualify
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h06
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output wr_req_t           req
);
    logic addr_hit;
    logic full_word;
    logic key_ok;

    always_comb begin
        addr_hit  = (addr == REG_ADDR);
        full_word = &be;
        key_ok    = (wdata[DATA_W-1 -: KEY_W] == UNLOCK_KEY);
        req.hit     = wr && addr_hit && full_word && key_ok;
        req.ext_val = wdata[EXT_BIT];
        req.mem_clr = req.hit && !wdata[MEM_BIT];
    end
endmodule

// File: rtl/sysctl_ext_defer.sv
module sysctl_ext_defer
    import sysctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  logic    busy,
    output logic    ext_en,
    output logic    idle
);
    logic pend_q;
    logic pend_val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_en     <= CTRL_RST.ext_bus_en;
            pend_q     <= 1'b0;
            pend_val_q <= 1'b0;
        end else if (req.hit) begin
            if (!busy) begin
                ext_en <= req.ext_val;
                pend_q <= 1'b0;
            end else begin
                pend_q     <= (req.ext_val != ext_en);
                pend_val_q <= req.ext_val;
            end
        end else if (pend_q && !busy) begin
            ext_en <= pend_val_q;
            pend_q <= 1'b0;
        end
    end

    assign idle = !pend_q;

    // R7: no movement of the enable across an edge with a busy bus
    p_ext_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ext_en));

    // R7: a pending change lands on the first idle edge
    p_pend_lands_r7: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !busy && !req.hit) |=> (idle && ext_en == $past(pend_val_q)));

    // R3/R8/R9: without a qualified write and with nothing pending, the enable holds
    p_ext_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!req.hit && idle) |=> $stable(ext_en));
endmodule

// File: rtl/sysctl_rd_port.sv
module sysctl_rd_port
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hit,
    input  ctrl_t             view,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (rd_hit) rdata <= pack_view(view);
        else             rdata <= '0;
    end

    // R4: key and reserved positions never carry data
    p_rdata_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:EXT_BIT+1] == '0);

    // R10: no strobe, no data
    p_rdata_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |=> (rdata == '0));
endmodule

// File: rtl/keyed_sysctl_reg.sv
module keyed_sysctl_reg
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h06
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_cycle_active,
    output logic              mem_enable,
    output logic              ext_bus_enable,
    output logic              change_done
);
    wr_req_t req;
    ctrl_t   view;
    logic    mem_en_q;
    logic    ext_en;
    logic    rd_hit;

    sysctl_wr_qualify #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_qual (
        .addr (bus_addr),
        .wr   (bus_wr),
        .be   (bus_be),
        .wdata(bus_wdata),
        .req  (req)
    );

    // One-way memory enable: only a clear is accepted
    always_ff @(posedge clk) begin
        if (rst)              mem_en_q <= CTRL_RST.mem_en;
        else if (req.mem_clr) mem_en_q <= 1'b0;
    end

    sysctl_ext_defer u_ext (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .busy  (ext_cycle_active),
        .ext_en(ext_en),
        .idle  (change_done)
    );

    always_comb begin
        view.mem_en     = mem_en_q;
        view.ext_bus_en = ext_en;
        rd_hit          = bus_rd && (bus_addr == REG_ADDR);
    end

    sysctl_rd_port u_rd (
        .clk  (clk),
        .rst  (rst),
        .rd_hit(rd_hit),
        .view (view),
        .rdata(bus_rdata)
    );

    assign mem_enable     = mem_en_q;
    assign ext_bus_enable = ext_en;

    // R5: once cleared, the memory enable stays cleared
    p_mem_one_way_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_enable |=> !mem_enable);

    // R3: a wrong key never moves the memory enable
    p_bad_key_mem_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata[DATA_W-1 -: KEY_W] != UNLOCK_KEY) |=> $stable(mem_enable));

    // R9: partial byte enables never move the memory enable
    p_partial_be_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !(&bus_be)) |=> $stable(mem_enable));

    // R8: foreign address reads return zero
    p_foreign_read_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr != REG_ADDR) |=> (bus_rdata == '0));
endmodule

// File: tb/keyed_sysctl_reg_tb.sv
`timescale 1ns/1ps
module keyed_sysctl_reg_tb;
    localparam int AW = 8;
    localparam logic [AW-1:0] RA = 8'h06;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] bus_addr;
    logic          bus_wr;
    logic          bus_rd;
    logic [1:0]    bus_be;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata;
    logic          ext_cycle_active;
    logic          mem_enable;
    logic          ext_bus_enable;
    logic          change_done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    keyed_sysctl_reg #(.ADDR_W(AW), .REG_ADDR(RA)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ext_cycle_active(ext_cycle_active),
        .mem_enable(mem_enable), .ext_bus_enable(ext_bus_enable),
        .change_done(change_done)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_be = 0; bus_addr = 0;
        bus_wdata = 0; ext_cycle_active = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [1:0] be, input logic [15:0] d);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        check("R1 mem", {15'b0, mem_enable}, 16'h1);
        check("R1 ext", {15'b0, ext_bus_enable}, 16'h0);
        check("R1 done", {15'b0, change_done}, 16'h1);
        check("R1 rdata", bus_rdata, 16'h0);
    endtask

    task automatic t_ext_toggle();
        logic [15:0] v;
        wr(RA, 2'b11, 16'h5A03);
        check("R2 R6 ext set", {15'b0, ext_bus_enable}, 16'h1);
        check("R2 mem kept", {15'b0, mem_enable}, 16'h1);
        rd(RA, v);
        check("R10 R4 read after set", v, 16'h0003);
        wr(RA, 2'b11, 16'h5A01);
        check("R6 ext clear", {15'b0, ext_bus_enable}, 16'h0);
        rd(RA, v);
        check("R10 read after clear", v, 16'h0001);
        check("R10 idle rdata", bus_rdata, 16'h0001);
        @(negedge clk);
        check("R10 rdata drops", bus_rdata, 16'h0000);
    endtask

    task automatic t_bad_key();
        wr(RA, 2'b11, 16'hA503);
        check("R3 ext A5 key", {15'b0, ext_bus_enable}, 16'h0);
        wr(RA, 2'b11, 16'h0002);
        check("R3 ext 00 key", {15'b0, ext_bus_enable}, 16'h0);
        wr(RA, 2'b11, 16'h5B00);
        check("R3 mem 5B key", {15'b0, mem_enable}, 16'h1);
    endtask

    task automatic t_partial_be();
        wr(RA, 2'b01, 16'h5A02);
        check("R9 low byte only", {15'b0, ext_bus_enable}, 16'h0);
        wr(RA, 2'b10, 16'h5A00);
        check("R9 high byte only", {15'b0, mem_enable}, 16'h1);
    endtask

    task automatic t_addr();
        logic [15:0] v;
        wr(RA + 8'h1, 2'b11, 16'h5A02);
        check("R8 foreign write ext", {15'b0, ext_bus_enable}, 16'h0);
        wr(8'h00, 2'b11, 16'h5A00);
        check("R8 foreign write mem", {15'b0, mem_enable}, 16'h1);
        rd(RA + 8'h2, v);
        check("R8 foreign read", v, 16'h0000);
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        wr(RA, 2'b11, 16'h5AFF);
        check("R4 ext via full word", {15'b0, ext_bus_enable}, 16'h1);
        rd(RA, v);
        check("R4 key and reserved read 0", v, 16'h0003);
    endtask

    task automatic t_defer();
        ext_cycle_active = 1'b1;
        wr(RA, 2'b11, 16'h5A01);
        check("R7 held while busy", {15'b0, ext_bus_enable}, 16'h1);
        check("R7 pending flag", {15'b0, change_done}, 16'h0);
        @(negedge clk);
        @(negedge clk);
        check("R7 still held", {15'b0, ext_bus_enable}, 16'h1);
        check("R7 still pending", {15'b0, change_done}, 16'h0);
        ext_cycle_active = 1'b0;
        @(negedge clk);
        check("R7 applied when idle", {15'b0, ext_bus_enable}, 16'h0);
        check("R7 done again", {15'b0, change_done}, 16'h1);
    endtask

    task automatic t_mem_clear();
        logic [15:0] v;
        wr(RA, 2'b11, 16'h5A02);
        check("R5 cleared", {15'b0, mem_enable}, 16'h0);
        check("R6 ext with clear", {15'b0, ext_bus_enable}, 16'h1);
        wr(RA, 2'b11, 16'h5A03);
        check("R5 cannot reset", {15'b0, mem_enable}, 16'h0);
        rd(RA, v);
        check("R5 read shows cleared", v, 16'h0002);
        do_reset();
        check("R5 reset restores", {15'b0, mem_enable}, 16'h1);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_ext_toggle();
        t_bad_key();
        t_partial_be();
        t_addr();
        t_reserved();
        t_defer();
        t_mem_clear();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule